// File: doc/BRIEF.md
# Angle-Matched One-Shot Pulse Channel

This block is one output channel of an engine ignition and injection timing unit. It watches a shared 16-bit crank-position value that a separate counter drives. When that value equals a programmed match angle, the channel starts a single pulse. The pulse length comes from a programmed width. The width counts down at half the system clock rate, so every width unit is worth two clocks. When the count reaches zero, the pulse ends and the channel is ready to fire again.

The host sets when each pulse starts and how long it lasts by writing two registers: the match angle and the width. Writes land in holding copies and move into the working copies only while the channel is idle. A pulse that is running therefore always completes with the settings it started with. Many channels share one crank-position bus. Each channel drives one ignition or injector output.

Top module: `angle_pulse_channel`

## Requirements
- R1: A synchronous reset deasserts `pulseOut`, clears the down-counter and sets both the held and working match and width values to zero. After reset the channel does not fire until a nonzero width has been written.
- R2: When the channel is idle, `crankPos` equals the working match value in cycle m and the working width is nonzero, `pulseOut` goes high in cycle m+1.
- R3: The counter decrements only on cycles in which an internal half-rate enable is high. That enable is low in the first cycle after reset is released (cycle 0) and alternates after that. For a width W that fires in cycle m, `pulseOut` stays high for 2W-1 cycles when m is even and for 2W cycles when m is odd.
- R4: A working width of zero never produces a pulse, even when the position matches.
- R5: A position match that arrives while `pulseOut` is high is ignored: there is no restart, no extension and no second pulse.
- R6: The channel re-arms at terminal count. A match in the first cycle in which `pulseOut` is low again starts a new pulse in the next cycle.
- R7: Register writes made while a pulse is active do not change that pulse. A new match value written during a pulse cannot trigger until the channel has gone idle.
- R8: A write made in cycle w while the channel is idle takes effect for a position match in cycle w+2.
- R9: A `crankPos` value that differs from the working match value does not start a pulse.
- R10: If reset is asserted during a pulse, `pulseOut` is low in the cycle after the reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| crankPos | input | 16 | Shared crank-position value |
| matchWrEn | input | 1 | Write strobe for the match angle |
| matchWrData | input | 16 | Match angle to write |
| widthWrEn | input | 1 | Write strobe for the pulse width |
| widthWrData | input | 16 | Pulse width to write, in half-rate ticks |
| pulseOut | output | 1 | Channel output, high while the count is nonzero |

## Verification
A corrupt counter shows as a pulse that is too long or too short. This is visible at the falling edge of `pulseOut`, at most two cycles after the correct end. A comparator that re-arms at the wrong time shows up at the ports in one of two ways: a second pulse, or a stretched pulse right after a duplicate match. If the working registers are copied while the channel is busy, the current pulse changes length, or a new angle fires one cycle after it is matched. The scoreboard checks every pulse against the start cycle and the parity-dependent length that it predicts.

// File: rtl/angle_pulse_pkg.sv
package angle_pulse_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic load;    // start a pulse: count <= working width
    logic dec;     // half-rate decrement of the running count
    logic commit;  // copy held register values into the working copies
  } chanStrobes_t;
endpackage

// File: rtl/angle_pulse_ctrl.sv
module angle_pulse_ctrl
  import angle_pulse_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] crankPos,
  input  logic [POS_W-1:0] activeMatch,
  input  logic [CNT_W-1:0] activeWidth,
  input  logic             cntIdle,
  output chanStrobes_t     strobes
);

  logic tickR;
  logic posHit;
  logic widthNz;

  // Half-rate enable: low in the first cycle after reset, then alternating
  always_ff @(posedge clk) begin
    if (rst) tickR <= 1'b0;
    else     tickR <= ~tickR;
  end

  assign posHit  = (crankPos == activeMatch);
  assign widthNz = |activeWidth;

  always_comb begin
    strobes.load   = cntIdle & posHit & widthNz;
    strobes.dec    = ~cntIdle & tickR;
    strobes.commit = cntIdle & ~strobes.load;
  end

  // R3: the enable alternates on every cycle once reset is released
  a_r3_tick_alternates: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tickR != $past(tickR)));

endmodule

// File: rtl/angle_pulse_dp.sv
module angle_pulse_dp
  import angle_pulse_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  chanStrobes_t     strobes,
  input  logic             matchWrEn,
  input  logic [POS_W-1:0] matchWrData,
  input  logic             widthWrEn,
  input  logic [CNT_W-1:0] widthWrData,
  output logic [POS_W-1:0] activeMatch,
  output logic [CNT_W-1:0] activeWidth,
  output logic             cntIdle,
  output logic             pulseOut
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [POS_W-1:0] heldMatch;
  logic [CNT_W-1:0] heldWidth;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldMatch   <= '0;
      heldWidth   <= '0;
      activeMatch <= '0;
      activeWidth <= '0;
      count       <= '0;
    end else begin
      if (matchWrEn) heldMatch <= matchWrData;
      if (widthWrEn) heldWidth <= widthWrData;
      if (strobes.commit) begin
        activeMatch <= heldMatch;
        activeWidth <= heldWidth;
      end
      if (strobes.load)     count <= activeWidth;
      else if (strobes.dec) count <= count - CNT_ONE;
    end
  end

  assign cntIdle  = (count == '0);
  assign pulseOut = ~cntIdle;

  // R2: a start loads exactly the working width
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (count == $past(activeWidth)));

  // R5 / R3: while busy the count only holds or steps down by one
  a_r5_busy_monotonic: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> ((count == $past(count)) || (count == $past(count) - CNT_ONE)));

  // R7: working copies are frozen while a pulse runs
  a_r7_active_hold: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> ($stable(activeWidth) && $stable(activeMatch)));

  // R4: an idle channel with zero width stays idle
  a_r4_zero_width_idle: assert property (@(posedge clk) disable iff (rst)
    ((count == '0) && (activeWidth == '0)) |=> (count == '0));

endmodule

// File: rtl/angle_pulse_channel.sv
module angle_pulse_channel
  import angle_pulse_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] crankPos,
  input  logic             matchWrEn,
  input  logic [POS_W-1:0] matchWrData,
  input  logic             widthWrEn,
  input  logic [CNT_W-1:0] widthWrData,
  output logic             pulseOut
);

  chanStrobes_t     strobes;
  logic [POS_W-1:0] activeMatch;
  logic [CNT_W-1:0] activeWidth;
  logic             cntIdle;

  angle_pulse_ctrl #(.POS_W(POS_W), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rst(rst), .crankPos(crankPos),
    .activeMatch(activeMatch), .activeWidth(activeWidth),
    .cntIdle(cntIdle), .strobes(strobes)
  );

  angle_pulse_dp #(.POS_W(POS_W), .CNT_W(CNT_W)) dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .matchWrEn(matchWrEn), .matchWrData(matchWrData),
    .widthWrEn(widthWrEn), .widthWrData(widthWrData),
    .activeMatch(activeMatch), .activeWidth(activeWidth),
    .cntIdle(cntIdle), .pulseOut(pulseOut)
  );

  // R10 / R1: reset forces the output low by the next cycle
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !pulseOut);

endmodule

// File: tb/angle_pulse_channel_test.sv
module angle_pulse_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDLE_POS = 16'h0ABC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] crankPos = IDLE_POS;
  logic        matchWrEn = 1'b0;
  logic [15:0] matchWrData = '0;
  logic        widthWrEn = 1'b0;
  logic [15:0] widthWrData = '0;
  logic        pulseOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int startQ[$];
  int lenQ[$];
  bit monEn = 1'b0;
  bit inPulse = 1'b0;
  int curStart = 0;
  int curLen = 0;
  int lastFall = 0;

  angle_pulse_channel uut (
    .clk(clk), .rst(rst), .crankPos(crankPos),
    .matchWrEn(matchWrEn), .matchWrData(matchWrData),
    .widthWrEn(widthWrEn), .widthWrData(widthWrData),
    .pulseOut(pulseOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // cycle index since reset release (cycle 0 ends at the first edge with rst low)
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: measures each pulse and compares with the queue
  always @(negedge clk) begin
    if (monEn && !rst) begin
      if (pulseOut && !inPulse) begin
        inPulse  = 1'b1;
        curStart = cyc;
        curLen   = 1;
      end else if (pulseOut) begin
        curLen++;
      end else if (inPulse) begin
        inPulse  = 1'b0;
        lastFall = cyc;
        if (startQ.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R4/R5/R9 unexpected pulse actual=start %0d expected=none", curStart);
        end else begin
          checkEq("R2 pulse start cycle", curStart, startQ.pop_front());
          checkEq("R3 pulse length", curLen, lenQ.pop_front());
        end
      end
    end
  end

  task automatic writeRegs(logic [15:0] m, logic [15:0] w);
    matchWrEn = 1'b1; matchWrData = m;
    widthWrEn = 1'b1; widthWrData = w;
    @(negedge clk);
    matchWrEn = 1'b0; widthWrEn = 1'b0;
    @(negedge clk);  // now in cycle w+2 (R8)
  endtask

  // present a match for one cycle; push expected pulse if one should fire
  task automatic fire(logic [15:0] pos, int w, bit expect_pulse);
    crankPos = pos;
    if (expect_pulse) begin
      startQ.push_back(cyc + 1);
      lenQ.push_back((cyc % 2 == 1) ? 2*w : 2*w - 1);
    end
    @(negedge clk);
    crankPos = IDLE_POS;
  endtask

  task automatic toParity(int par);
    while (cyc % 2 != par) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      if (startQ.size() == 0 && !inPulse && !pulseOut) break;
    end
    checkEq("R3 scoreboard drained", startQ.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1 output low in reset", pulseOut, 0);
    rst = 1'b0;
    monEn = 1'b1;
    // R1: registers are zero, so position 0 matches but width 0 must not fire
    crankPos = 16'h0000;
    repeat (6) @(negedge clk);
    checkEq("R1 no fire after reset", pulseOut, 0);
    crankPos = IDLE_POS;

    // R8 + R2 + R3: write then fire two cycles later, even parity
    writeRegs(16'd100, 16'd3);
    toParity(0);
    fire(16'd100, 3, 1'b1);
    waitIdle();
    // R3: odd parity
    toParity(1);
    fire(16'd100, 3, 1'b1);
    waitIdle();

    // R9: wrong position does not fire
    fire(16'd101, 3, 1'b0);
    repeat (4) @(negedge clk);
    checkEq("R9 mismatch no pulse", pulseOut, 0);

    // R5: repeated match during the pulse is ignored
    toParity(0);
    fire(16'd100, 3, 1'b1);
    @(negedge clk);
    fire(16'd100, 3, 1'b0);
    fire(16'd100, 3, 1'b0);
    waitIdle();

    // R7: writes during a pulse do not disturb it
    writeRegs(16'd100, 16'd4);
    toParity(1);
    fire(16'd100, 4, 1'b1);
    writeRegs(16'd200, 16'd1);
    fire(16'd200, 1, 1'b0);  // new angle during busy must not fire
    waitIdle();
    repeat (2) @(negedge clk);
    toParity(0);
    fire(16'd200, 1, 1'b1);  // new settings now in force
    waitIdle();

    // R6: re-arm at terminal count, match in the first low cycle
    writeRegs(16'd200, 16'd2);
    toParity(1);
    fire(16'd200, 2, 1'b1);
    while (!(inPulse == 1'b0 && pulseOut == 1'b0 && lastFall == cyc)) begin
      @(negedge clk); #1;
    end
    checkEq("R6 first low cycle", pulseOut, 0);
    fire(16'd200, 2, 1'b1);
    waitIdle();

    // R4: zero width never fires
    writeRegs(16'd300, 16'd0);
    fire(16'd300, 0, 1'b0);
    repeat (4) @(negedge clk);
    checkEq("R4 zero width no pulse", pulseOut, 0);

    // R10: reset during a pulse
    writeRegs(16'd300, 16'd10);
    fire(16'd300, 10, 1'b0);
    monEn = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R10 pulse running before reset", pulseOut, 1);
    rst = 1'b1;
    @(negedge clk);
    checkEq("R10 output low after reset", pulseOut, 0);
    rst = 1'b0;
    crankPos = 16'd300;
    repeat (4) @(negedge clk);
    checkEq("R1 registers cleared by reset", pulseOut, 0);
    crankPos = IDLE_POS;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule